// File: doc/BRIEF.md
# Successive-Approximation ADC Sequencer

This block runs a 14-bit successive-approximation converter over three wires: a convert strobe, a serial clock, and a serial data line coming back. A request arrives either as a pulse on `start_i` or from an internal rate timer that is enabled by `auto_en_i`. The request raises the convert strobe. The block holds the strobe high for a minimum width, then waits out the conversion time. That time depends on the speed mode, which is latched when the conversion is accepted. The block then sends a burst of exactly 14 serial clocks and samples the data line on each falling edge, most significant bit first. When the last bit is in, the block presents the finished word with a one-cycle `done_o` pulse.

Every analog limit is a parameter counted in system-clock cycles, rounded up from the nanosecond value: strobe width, conversion time per mode, minimum spacing between convert edges per mode, the gap between the last serial falling edge and the next convert edge, and the serial-clock half period. A request that arrives while a new conversion may not yet start is dropped and sets a sticky `overrun_o` flag.

A single state machine holds the sequence. Its states are IDLE, CONV, SHIFT and QUIET, with these transitions:
- IDLE→CONV on an accepted request.
- CONV→SHIFT once the latched conversion time has elapsed.
- SHIFT→QUIET when the burst reports its last bit.
- QUIET→CONV on an accepted request.
- QUIET→IDLE once the quiet gap has passed with no request.

Top module: `adc_conv_ctrl`

## Requirements
- R1: While reset is held and right after it, `cnv_o`, `sclk_o`, `done_o` and `overrun_o` are all low.
- R2: An accepted request raises `cnv_o` on the same clock edge that samples the request. `cnv_o` then stays high for exactly CNV_HIGH_CYC cycles.
- R3: The first rising `sclk_o` edge comes CONV_TURBO_CYC cycles after the convert rise when `turbo_i` was 1 at acceptance, and CONV_NORMAL_CYC cycles after it when `turbo_i` was 0. Changing `turbo_i` later has no effect on that conversion.
- R4: Each conversion produces exactly DATA_W (14) falling edges on `sclk_o`. The clock is high for SCK_HALF_CYC cycles and low for SCK_HALF_CYC cycles. `sclk_o` is low outside the burst and never high while `cnv_o` is high.
- R5: `sdo_i` is sampled on the clock edge that makes each `sclk_o` falling edge. The first sample is the most significant bit of `data_o`, and the fourteenth is bit 0.
- R6: `done_o` is high for exactly one cycle, on the edge of the last falling `sclk_o`. In that same cycle `data_o` holds the new word.
- R7: A new convert rise comes no sooner than CYCLE_TURBO_CYC cycles after the previous one (turbo) or CYCLE_NORMAL_CYC cycles after it (normal). The mode that counts is the one latched for the previous conversion.
- R8: A new convert rise comes no sooner than QUIET_CYC cycles after the last falling `sclk_o` of the previous burst.
- R9: A request that arrives while R7 or R8, or a conversion in progress, forbids a new start is dropped and starts nothing. It sets `overrun_o`, which stays high until reset.
- R10: While `auto_en_i` is high, a request is generated every RATE_CYC cycles. The first one is seen RATE_CYC edges after the first edge that samples `auto_en_i` high.
- R11: A start pulse and a timer request on the same edge count as a single request. They produce one conversion and no overrun.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Conversion request, sampled each edge |
| auto_en_i | input | 1 | Enables the free-running rate timer |
| turbo_i | input | 1 | Speed mode: 1 turbo, 0 normal; latched at acceptance |
| sdo_i | input | 1 | Serial data from the converter |
| cnv_o | output | 1 | Convert strobe |
| sclk_o | output | 1 | Serial clock to the converter |
| done_o | output | 1 | One-cycle pulse: `data_o` holds a new word |
| data_o | output | DATA_W | Assembled conversion result |
| overrun_o | output | 1 | Sticky flag: a request was dropped |

## Verification
The bench builds the block with these parameters:

| Parameter | Value |
|---|---|
| SCK_HALF_CYC | 1 |
| CNV_HIGH_CYC | 2 |
| CONV_TURBO_CYC / CONV_NORMAL_CYC | 6 / 9 |
| CYCLE_TURBO_CYC / CYCLE_NORMAL_CYC | 34 / 50 |
| QUIET_CYC | 3 |
| RATE_CYC | 60 |

With a one-cycle half period, the serial clock toggles every cycle and every falling edge lands on a sampling edge. With these values, back-to-back turbo requests are held back by the quiet gap (6+27+3 = 36 > 34), while back-to-back normal requests are held back by the cycle limit (9+27+3 = 39 < 50). Both spacing rules therefore decide real start times.

The short rate period lets a few hundred cycles show several timer requests, and it allows a start pulse to be placed on the same edge as a timer request. The result words include all-ones, all-zeros and alternating patterns, so a shift in the wrong direction or an off-by-one sample shows up in the data.

// File: rtl/adc_conv_pkg.sv
package adc_conv_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_CONV  = 2'd1,
        ST_SHIFT = 2'd2,
        ST_QUIET = 2'd3
    } conv_state_e;

endpackage

// File: rtl/adc_rate_timer.sv
module adc_rate_timer #(
    parameter int RATE_CYC = 125
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    output logic tick_o
);
    localparam int RATE_W = (RATE_CYC > 1) ? $clog2(RATE_CYC) : 1;
    localparam logic [RATE_W-1:0] LAST_L = RATE_W'(RATE_CYC - 1);

    logic [RATE_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            tick_o <= 1'b0;
        end else if (!en_i) begin
            cnt_q  <= '0;
            tick_o <= 1'b0;
        end else if (cnt_q == LAST_L) begin
            cnt_q  <= '0;
            tick_o <= 1'b1;
        end else begin
            cnt_q  <= cnt_q + 1'b1;
            tick_o <= 1'b0;
        end
    end

    // R10: requests from the timer are isolated single-cycle pulses
    assert_tick_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o);

endmodule

// File: rtl/adc_sck_deser.sv
module adc_sck_deser #(
    parameter int DATA_W       = 14,
    parameter int SCK_HALF_CYC = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              sdo_i,
    output logic              sclk_o,
    output logic              done_o,
    output logic [DATA_W-1:0] data_o
);
    localparam int HCNT_W = $clog2(SCK_HALF_CYC + 1);
    localparam int FALL_W = $clog2(DATA_W + 1);
    localparam logic [HCNT_W-1:0] HALF_L = HCNT_W'(SCK_HALF_CYC);
    localparam logic [FALL_W-1:0] LASTF_L = FALL_W'(DATA_W - 1);

    logic              active_q;
    logic [HCNT_W-1:0] hcnt_q;
    logic [FALL_W-1:0] falls_q;
    logic [DATA_W-1:0] shreg_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            hcnt_q   <= '0;
            falls_q  <= '0;
            shreg_q  <= '0;
            sclk_o   <= 1'b0;
            done_o   <= 1'b0;
            data_o   <= '0;
        end else begin
            done_o <= 1'b0;
            if (start_i) begin
                active_q <= 1'b1;
                sclk_o   <= 1'b1;
                hcnt_q   <= HCNT_W'(1);
                falls_q  <= '0;
            end else if (active_q) begin
                if (hcnt_q == HALF_L) begin
                    hcnt_q <= HCNT_W'(1);
                    if (sclk_o) begin
                        sclk_o  <= 1'b0;
                        shreg_q <= {shreg_q[DATA_W-2:0], sdo_i};
                        if (falls_q == LASTF_L) begin
                            active_q <= 1'b0;
                            done_o   <= 1'b1;
                            data_o   <= {shreg_q[DATA_W-2:0], sdo_i};
                        end else begin
                            falls_q <= falls_q + 1'b1;
                        end
                    end else begin
                        sclk_o <= 1'b1;
                    end
                end else begin
                    hcnt_q <= hcnt_q + 1'b1;
                end
            end
        end
    end

    // R6: the word is reported on the edge of the final falling serial clock
    assert_done_on_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> ($fell(sclk_o) && !sclk_o));

    // R4: a new burst is never requested while one is still running
    assert_no_restart_R4: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |-> !active_q);

endmodule

// File: rtl/adc_conv_ctrl.sv
module adc_conv_ctrl
    import adc_conv_pkg::*;
#(
    parameter int DATA_W           = 14,
    parameter int CNV_HIGH_CYC     = 3,
    parameter int CONV_TURBO_CYC   = 80,
    parameter int CONV_NORMAL_CYC  = 105,
    parameter int CYCLE_TURBO_CYC  = 100,
    parameter int CYCLE_NORMAL_CYC = 125,
    parameter int QUIET_CYC        = 5,
    parameter int SCK_HALF_CYC     = 2,
    parameter int RATE_CYC         = 125
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              auto_en_i,
    input  logic              turbo_i,
    input  logic              sdo_i,
    output logic              cnv_o,
    output logic              sclk_o,
    output logic              done_o,
    output logic [DATA_W-1:0] data_o,
    output logic              overrun_o
);
    localparam int CYC_MAX  = (CYCLE_TURBO_CYC > CYCLE_NORMAL_CYC) ? CYCLE_TURBO_CYC : CYCLE_NORMAL_CYC;
    localparam int CONV_MAX = (CONV_TURBO_CYC > CONV_NORMAL_CYC) ? CONV_TURBO_CYC : CONV_NORMAL_CYC;
    localparam int ELAP_MAX = (CYC_MAX > CONV_MAX) ? CYC_MAX : CONV_MAX;
    localparam int ELAP_W   = $clog2(ELAP_MAX + 1);
    localparam int QCNT_W   = $clog2(QUIET_CYC + 1);

    localparam logic [ELAP_W-1:0] ELAP_MAX_L = ELAP_W'(ELAP_MAX);
    localparam logic [ELAP_W-1:0] CNVH_L     = ELAP_W'(CNV_HIGH_CYC);
    localparam logic [ELAP_W-1:0] CONV_T_L   = ELAP_W'(CONV_TURBO_CYC);
    localparam logic [ELAP_W-1:0] CONV_N_L   = ELAP_W'(CONV_NORMAL_CYC);
    localparam logic [ELAP_W-1:0] CYC_T_L    = ELAP_W'(CYCLE_TURBO_CYC);
    localparam logic [ELAP_W-1:0] CYC_N_L    = ELAP_W'(CYCLE_NORMAL_CYC);
    localparam logic [QCNT_W-1:0] QUIET_L    = QCNT_W'(QUIET_CYC);

    conv_state_e       state_q, state_nx;
    logic [ELAP_W-1:0] elapsed_q;
    logic [ELAP_W-1:0] cyc_lat_q;
    logic [ELAP_W-1:0] conv_lat_q;
    logic [QCNT_W-1:0] qcnt_q;
    logic              tick;
    logic              trig;
    logic              start_ok;
    logic              accept;
    logic              go_shift;
    logic              rx_done;

    adc_rate_timer #(
        .RATE_CYC (RATE_CYC)
    ) u_rate (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (auto_en_i),
        .tick_o (tick)
    );

    adc_sck_deser #(
        .DATA_W       (DATA_W),
        .SCK_HALF_CYC (SCK_HALF_CYC)
    ) u_deser (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (go_shift),
        .sdo_i   (sdo_i),
        .sclk_o  (sclk_o),
        .done_o  (rx_done),
        .data_o  (data_o)
    );

    assign done_o = rx_done;
    assign trig   = start_i | tick;

    always_comb begin
        start_ok = 1'b0;
        if (elapsed_q >= cyc_lat_q) begin
            start_ok = (state_q == ST_IDLE) || ((state_q == ST_QUIET) && (qcnt_q >= QUIET_L));
        end
    end

    assign accept   = trig && start_ok;
    assign go_shift = (state_q == ST_CONV) && (elapsed_q == conv_lat_q);

    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_IDLE:  if (accept)   state_nx = ST_CONV;
            ST_CONV:  if (go_shift) state_nx = ST_SHIFT;
            ST_SHIFT: if (rx_done)  state_nx = ST_QUIET;
            ST_QUIET: begin
                if (accept)                 state_nx = ST_CONV;
                else if (qcnt_q >= QUIET_L) state_nx = ST_IDLE;
            end
            default:  state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            elapsed_q  <= ELAP_MAX_L;
            cyc_lat_q  <= '0;
            conv_lat_q <= CONV_N_L;
            qcnt_q     <= '0;
            cnv_o      <= 1'b0;
            overrun_o  <= 1'b0;
        end else begin
            if (accept) begin
                elapsed_q  <= ELAP_W'(1);
                cnv_o      <= 1'b1;
                cyc_lat_q  <= turbo_i ? CYC_T_L : CYC_N_L;
                conv_lat_q <= turbo_i ? CONV_T_L : CONV_N_L;
            end else begin
                if (elapsed_q < ELAP_MAX_L) elapsed_q <= elapsed_q + 1'b1;
                if ((state_q == ST_CONV) && (elapsed_q == CNVH_L)) cnv_o <= 1'b0;
            end
            if (trig && !start_ok) overrun_o <= 1'b1;
            if ((state_q == ST_SHIFT) && rx_done) qcnt_q <= QCNT_W'(2);
            else if ((state_q == ST_QUIET) && (qcnt_q < QUIET_L)) qcnt_q <= qcnt_q + 1'b1;
        end
    end

    // R7: convert edges respect the minimum cycle time of the previous mode
    assert_cnv_spacing_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cnv_o) |-> ($past(elapsed_q) >= $past(cyc_lat_q)));

    // R8: a convert edge follows the last serial fall by the quiet gap
    assert_cnv_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cnv_o) |-> (($past(state_q) == ST_IDLE) || ($past(qcnt_q) >= QUIET_L)));

    // R4: the serial clock never toggles high while the strobe is high
    assert_sclk_cnv_apart_R4: assert property (@(posedge clk) disable iff (!rst_n)
        sclk_o |-> !cnv_o);

    // R9: the overrun flag is sticky
    assert_overrun_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        overrun_o |=> overrun_o);

    // R6: done is a single-cycle pulse
    assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

endmodule

// File: tb/adc_conv_ctrl_bench.sv
module adc_conv_ctrl_bench;
    localparam int W     = 14;
    localparam int CNVH  = 2;
    localparam int CT    = 6;
    localparam int CN    = 9;
    localparam int CYT   = 34;
    localparam int CYN   = 50;
    localparam int QUIET = 3;
    localparam int HALF  = 1;
    localparam int RATE  = 60;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0, auto_en = 1'b0, turbo = 1'b0, sdo = 1'b0;
    logic cnv, sclk, done, overrun;
    logic [W-1:0] data;

    always #2 clk = ~clk;

    adc_conv_ctrl #(
        .DATA_W(W), .CNV_HIGH_CYC(CNVH), .CONV_TURBO_CYC(CT), .CONV_NORMAL_CYC(CN),
        .CYCLE_TURBO_CYC(CYT), .CYCLE_NORMAL_CYC(CYN), .QUIET_CYC(QUIET),
        .SCK_HALF_CYC(HALF), .RATE_CYC(RATE)
    ) u_adc_conv_ctrl (
        .clk(clk), .rst_n(rst_n), .start_i(start), .auto_en_i(auto_en),
        .turbo_i(turbo), .sdo_i(sdo), .cnv_o(cnv), .sclk_o(sclk),
        .done_o(done), .data_o(data), .overrun_o(overrun)
    );

    int checks = 0, fails = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic logic [W-1:0] word_f(input int i);
        if (i == 0) return '1;
        if (i == 1) return '0;
        if (i == 2) return W'(14'h2AAA);
        return W'((i * 9973 + 341) & 16'h3FFF);
    endfunction

    // behavioural reference: absolute edge times computed at acceptance
    int n = 0;
    int e0 = -1000, m_conv = 0, m_cyc = 0, lastfall = -1000, ready_at = 0;
    int acc_cnt = 0, en_k = 0;
    bit pend = 0, m_ovr = 0;
    logic [W-1:0] m_word = '0;
    bit exp_cnv = 0, exp_sclk = 0, exp_done = 0;

    always @(posedge clk) begin
        if (rst_n) begin
            bit tk, trig;
            int r;
            tk = pend;
            if (auto_en) begin
                en_k++;
                pend = (en_k % RATE == 0);
            end else begin
                en_k = 0;
                pend = 0;
            end
            trig = start | tk;
            if (trig && n >= ready_at) begin
                e0 = n;
                m_conv = turbo ? CT : CN;
                m_cyc = turbo ? CYT : CYN;
                lastfall = n + m_conv + (2 * W - 1) * HALF;
                ready_at = (n + m_cyc > lastfall + QUIET) ? n + m_cyc : lastfall + QUIET;
                m_word = word_f(acc_cnt);
                acc_cnt++;
            end else if (trig) begin
                m_ovr = 1;
            end
            exp_cnv = (n >= e0) && (n < e0 + CNVH);
            r = n - (e0 + m_conv);
            exp_sclk = (r >= 0) && (r < (2 * W - 1) * HALF) && ((r / HALF) % 2 == 0);
            exp_done = (n == lastfall);
            n++;
        end
    end

    // comparison, converter model and edge-spacing checks
    int rise_cnt = 0, prev_rise = -1000, prev_cyc = 0, rise_conv = 0, last_fall = -1000, bit_i = -1;
    bit p_cnv = 0, p_sclk = 0, first_pending = 0;
    logic [W-1:0] adc_word = '0;

    always @(negedge clk) begin
        if (rst_n && n > 0 && !finished) begin
            int t;
            t = n - 1;
            chk(cnv === exp_cnv, "R2 cnv", cnv, exp_cnv);
            chk(sclk === exp_sclk, "R4 sclk", sclk, exp_sclk);
            chk(done === exp_done, "R6 done", done, exp_done);
            chk(overrun === m_ovr, "R9 overrun", overrun, m_ovr);
            if (exp_done) chk(data === m_word, "R5 data", data, m_word);
            if (cnv && !p_cnv) begin
                if (rise_cnt > 0) begin
                    chk(t - prev_rise >= prev_cyc, "R7 spacing", t - prev_rise, prev_cyc);
                    chk(t - last_fall >= QUIET, "R8 quiet", t - last_fall, QUIET);
                end
                adc_word = word_f(rise_cnt);
                rise_cnt++;
                bit_i = W - 1;
                prev_rise = t;
                prev_cyc = m_cyc;
                rise_conv = m_conv;
                first_pending = 1;
            end
            if (sclk && !p_sclk && first_pending) begin
                chk(t - prev_rise == rise_conv, "R3 conv wait", t - prev_rise, rise_conv);
                first_pending = 0;
            end
            if (!sclk && p_sclk) begin
                bit_i--;
                last_fall = t;
            end
            sdo = (bit_i >= 0) ? adc_word[bit_i] : 1'b0;
            p_cnv = cnv;
            p_sclk = sclk;
        end
    end

    task automatic pulse_start();
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    initial begin
        int base;
        repeat (4) @(negedge clk);
        chk(!cnv && !sclk && !done && !overrun, "R1 reset", {cnv, sclk, done, overrun}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!cnv && !sclk && !done && !overrun, "R1 after reset", {cnv, sclk, done, overrun}, 0);

        // turbo single conversion
        turbo = 1'b1;
        pulse_start();
        repeat (60) @(negedge clk);

        // normal conversion, mode flips mid-conversion (R3)
        turbo = 1'b0;
        pulse_start();
        repeat (3) @(negedge clk);
        turbo = 1'b1;
        repeat (70) @(negedge clk);
        turbo = 1'b0;

        // R11: start coincides with first timer request
        base = rise_cnt;
        auto_en = 1'b1;
        repeat (RATE) @(negedge clk);
        start = 1'b1;
        auto_en = 1'b0;
        @(negedge clk);
        start = 1'b0;
        repeat (80) @(negedge clk);
        chk(rise_cnt - base == 1, "R11 merged count", rise_cnt - base, 1);
        chk(overrun == 1'b0, "R11 no overrun", overrun, 0);

        // R10: free-running timer for 300 edges
        base = rise_cnt;
        auto_en = 1'b1;
        repeat (300) @(negedge clk);
        auto_en = 1'b0;
        repeat (100) @(negedge clk);
        chk(rise_cnt - base == 5, "R10 timer count", rise_cnt - base, 5);
        chk(overrun == 1'b0, "R10 no overrun", overrun, 0);

        // R9: request during a conversion is dropped
        base = rise_cnt;
        pulse_start();
        repeat (2) @(negedge clk);
        pulse_start();
        repeat (80) @(negedge clk);
        chk(rise_cnt - base == 1, "R9 dropped request", rise_cnt - base, 1);
        chk(overrun == 1'b1, "R9 sticky flag", overrun, 1);

        // back-to-back: turbo limited by quiet gap, normal by cycle time
        turbo = 1'b1;
        start = 1'b1;
        repeat (200) @(negedge clk);
        turbo = 1'b0;
        repeat (200) @(negedge clk);
        start = 1'b0;
        repeat (80) @(negedge clk);
        chk(rise_cnt == acc_cnt, "R7 total conversions", rise_cnt, acc_cnt);
        finish_run();
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
        finish_run();
    end

endmodule